// File: doc/BRIEF.md
# Time-Division Output Poller

This block feeds a serial link encoder with a fixed, repeating frame of 21 word slots. Each of slots 0 to 17 belongs to one input channel. In its slot, a channel either sends the word at the head of its FIFO or, if that FIFO is empty, a placeholder word. Slot 18 carries a fixed synchronization marker. Slots 19 and 20 carry link idle codes. The receiver finds the source of each word from the word's position after the marker, so the frame never varies.

Channel words are rewritten as they pass through. Bits 27:24 of an incoming word are a source-ID field that the slot position already implies, so the block reuses two of those bits:
- bit 27 becomes the received-parity-error flag;
- bit 26 becomes a freshly computed odd-parity bit for the whole outgoing word.

The block moves one slot per strobe of the slower output clock domain. It sends nothing until all of these hold: the link is up, the block is enabled, and a trigger has been seen since the link last came up.

Top module: `tdm_out_poller`

## Requirements
- R1: After reset, `slot_num` is 18, `tx_ctl` is 00, `tx_data` is zero and no `fifo_pop` bit is set.
- R2: While active, each `adv_en` strobe registers one output word and advances `slot_num` by one modulo 21 (20 wraps to 0). Without a strobe, `tx_data`, `tx_ctl` and `slot_num` hold their values.
- R3: A strobe in slot 18 sends 0xD0000000 with `tx_ctl` 01.
- R4: A strobe in slot 19 or 20 sends the link idle code: `tx_ctl` 00 with `tx_data` zero.
- R5: A strobe in a slot 0..17 whose FIFO is not empty sets exactly that channel's `fifo_pop` bit in the same cycle and sends the word with `tx_ctl` 01. Bits 31:28 and 25:0 of the sent word equal the FIFO data bits, except bit 26 (see R7). Each FIFO entry is 33 bits: bit 32 is the received-parity-error flag and bits 31:0 are the data, channel c at `fifo_rd_data[33c +: 33]`, shown ahead before the pop.
- R6: Bit 27 of a sent channel word equals the entry's received-parity-error flag.
- R7: Bit 26 of a sent channel word is chosen so that all 32 bits have odd parity.
- R8: A strobe in a slot 0..17 whose FIFO is empty pops nothing and sends `{4'b0000, slot[3:0], 24'h0}` with `tx_ctl` 01.
- R9: With link and enable up but no `trig_seen` pulse since the link came up, the output stays at the idle code, `slot_num` stays 18 and nothing is popped. Arming takes effect one clock after the pulse.
- R10: While `link_up` is low, the output is the idle code, `slot_num` is 18 and nothing is popped. Arming is lost, so a new trigger is needed after the link returns.
- R11: While `run_en` is low, the block behaves as in R10 but keeps its arming. When `run_en` rises, the frame restarts at slot 18.
- R12: `tx_ctl` never takes the values 10 or 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_en | input | 1 | Slot-advance strobe from the output clock domain |
| run_en | input | 1 | Active-mode enable |
| link_up | input | 1 | Serial link is synchronized |
| trig_seen | input | 1 | Trigger pulse that arms output |
| fifo_empty | input | 18 | Per-channel FIFO empty flags |
| fifo_rd_data | input | 594 | Per-channel show-ahead FIFO heads, 33 bits each |
| fifo_pop | output | 18 | Per-channel acknowledge/pop |
| tx_data | output | 32 | Word to link encoder |
| tx_ctl | output | 2 | Encoder write control (00 idle, 01 data) |
| slot_num | output | 5 | Current poll slot |

## Verification
The bench targets four kinds of corner case:
- **Wrap from slot 20 to slot 0.** A design with an off-by-one frame length would shift every channel's position, and every later word would be misattributed.
- **Parity rewrite.** Words are chosen so the correct bit 26 is sometimes 0 and sometimes 1, and some words arrive with a parity error. A design that dropped the error flag, or computed parity before inserting it, would fail the odd-parity and bit-27 checks.
- **Two words queued in one channel.** A design that popped more than once per frame, or popped on cycles without a strobe, would send the second word a frame early.
- **Loss of the link or the enable mid-frame.** A design that kept counting, or kept its arming across a link loss, would resume at the wrong slot or send data without a fresh trigger.

// File: rtl/tdm_out_poller.sv
module tdm_out_poller #(
  parameter int NCH    = 18,
  parameter int NIDLE  = 2,
  parameter logic [31:0] SPACER = 32'hD000_0000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv_en,
  input  logic                 run_en,
  input  logic                 link_up,
  input  logic                 trig_seen,
  input  logic [NCH-1:0]       fifo_empty,
  input  logic [NCH*33-1:0]    fifo_rd_data,
  output logic [NCH-1:0]       fifo_pop,
  output logic [31:0]          tx_data,
  output logic [1:0]           tx_ctl,
  output logic [$clog2(NCH+1+NIDLE)-1:0] slot_num
);
  localparam int NSLOT = NCH + 1 + NIDLE;
  localparam int AW    = $clog2(NSLOT);
  localparam logic [AW-1:0] SPC_SLOT  = AW'(NCH);
  localparam logic [AW-1:0] LAST_SLOT = AW'(NSLOT - 1);
  localparam logic [1:0] CTL_IDLE = 2'b00;
  localparam logic [1:0] CTL_DATA = 2'b01;

  logic [AW-1:0] slot_q;
  logic          armed_q;
  logic          active;
  logic          is_chan;
  logic [AW-1:0] sel;
  logic [32:0]   head;
  logic          have;
  logic [31:0]   chan_w, empty_w, nxt_data;
  logic [1:0]    nxt_ctl;

  assign active  = run_en & link_up & armed_q;
  assign is_chan = slot_q < SPC_SLOT;
  assign sel     = is_chan ? slot_q : '0;
  assign head    = fifo_rd_data[int'(sel)*33 +: 33];
  assign have    = is_chan & ~fifo_empty[sel];

  always_comb begin
    chan_w     = head[31:0];
    chan_w[27] = head[32];
    chan_w[26] = 1'b0;
    chan_w[26] = ~^chan_w;
  end

  assign empty_w = {4'b0000, 4'(slot_q), 24'h0};

  always_comb begin
    if (is_chan) begin
      nxt_data = have ? chan_w : empty_w;
      nxt_ctl  = CTL_DATA;
    end else if (slot_q == SPC_SLOT) begin
      nxt_data = SPACER;
      nxt_ctl  = CTL_DATA;
    end else begin
      nxt_data = '0;
      nxt_ctl  = CTL_IDLE;
    end
  end

  assign fifo_pop = (adv_en & active & have) ? (NCH'(1) << sel) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q  <= SPC_SLOT;
      armed_q <= 1'b0;
      tx_data <= '0;
      tx_ctl  <= CTL_IDLE;
    end else begin
      armed_q <= link_up & (armed_q | trig_seen);
      if (!active) begin
        slot_q  <= SPC_SLOT;
        tx_data <= '0;
        tx_ctl  <= CTL_IDLE;
      end else if (adv_en) begin
        slot_q  <= (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
        tx_data <= nxt_data;
        tx_ctl  <= nxt_ctl;
      end
    end
  end

  assign slot_num = slot_q;
endmodule
// File: rtl/tdm_out_poller_chk.sv
module tdm_out_poller_chk #(
  parameter int NCH    = 18,
  parameter int NIDLE  = 2,
  parameter logic [31:0] SPACER = 32'hD000_0000
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 adv_en,
  input logic                 link_up,
  input logic                 active,
  input logic [NCH-1:0]       fifo_empty,
  input logic [NCH-1:0]       fifo_pop,
  input logic [31:0]          tx_data,
  input logic [1:0]           tx_ctl,
  input logic [$clog2(NCH+1+NIDLE)-1:0] slot_num
);
  localparam int NSLOT = NCH + 1 + NIDLE;
  localparam int AW    = $clog2(NSLOT);

  p_ctl_legal_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ctl != 2'b10 && tx_ctl != 2'b11);

  p_pop_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fifo_pop));

  p_no_empty_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_pop & fifo_empty) == '0);

  p_slot_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && active) |=> slot_num ==
      (($past(slot_num) == AW'(NSLOT-1)) ? '0 : $past(slot_num) + 1'b1));

  p_spacer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && active && slot_num == AW'(NCH)) |=> (tx_data == SPACER && tx_ctl == 2'b01));

  p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && active && slot_num > AW'(NCH)) |=> (tx_ctl == 2'b00 && tx_data == '0));

  p_odd_par_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|fifo_pop) |=> (^tx_data && tx_ctl == 2'b01));

  p_link_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !link_up |=> (tx_ctl == 2'b00 && slot_num == AW'(NCH)));

  p_link_nopop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !link_up |-> fifo_pop == '0);
endmodule

bind tdm_out_poller tdm_out_poller_chk #(.NCH(NCH), .NIDLE(NIDLE), .SPACER(SPACER)) i_chk (
  .clk(clk), .rst_n(rst_n), .adv_en(adv_en), .link_up(link_up), .active(active),
  .fifo_empty(fifo_empty), .fifo_pop(fifo_pop), .tx_data(tx_data),
  .tx_ctl(tx_ctl), .slot_num(slot_num)
);
// File: tb/test_tdm_out_poller.sv
module test_tdm_out_poller;
  localparam int NCH = 18;
  localparam int NSLOT = 21;
  localparam int DEPTH = 8;

  typedef struct {
    logic [31:0] data;
    logic [1:0]  ctl;
    int          slot;
    string       tag;
  } exp_t;

  logic clk = 0;
  logic rst_n = 0;
  logic adv_en = 0, run_en = 0, link_up = 0, trig_seen = 0;
  logic [NCH-1:0] fifo_empty;
  logic [NCH*33-1:0] fifo_rd_data;
  logic [NCH-1:0] fifo_pop;
  logic [31:0] tx_data;
  logic [1:0] tx_ctl;
  logic [4:0] slot_num;

  tdm_out_poller i_tdm_out_poller (
    .clk(clk), .rst_n(rst_n), .adv_en(adv_en), .run_en(run_en), .link_up(link_up),
    .trig_seen(trig_seen), .fifo_empty(fifo_empty), .fifo_rd_data(fifo_rd_data),
    .fifo_pop(fifo_pop), .tx_data(tx_data), .tx_ctl(tx_ctl), .slot_num(slot_num)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  logic [32:0] mem [NCH][DEPTH];
  int cnt [NCH];
  int slot_m = 18;
  bit armed_m = 0;
  exp_t sb[$];
  exp_t last;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic refresh();
    for (int c = 0; c < NCH; c++) begin
      fifo_empty[c] = (cnt[c] == 0);
      fifo_rd_data[c*33 +: 33] = (cnt[c] > 0) ? mem[c][0] : 33'h0;
    end
  endtask

  task automatic load(input int c, input logic [31:0] d, input logic perr);
    mem[c][cnt[c]] = {perr, d};
    cnt[c]++;
    refresh();
  endtask

  function automatic logic [31:0] chan_word(input logic [32:0] e);
    logic [31:0] w;
    w = e[31:0];
    w[27] = e[32];
    w[26] = 1'b0;
    w[26] = ~^w;
    return w;
  endfunction

  task automatic tick(input bit adv, input string why);
    exp_t it;
    logic [NCH-1:0] exp_pop;
    bit act;
    @(negedge clk);
    adv_en = adv;
    #1;
    act = run_en && link_up && armed_m;
    exp_pop = '0;
    if (!act) begin
      it = '{32'h0, 2'b00, 18, why};
    end else if (adv) begin
      if (slot_m < NCH) begin
        if (cnt[slot_m] > 0) begin
          exp_pop[slot_m] = 1'b1;
          it = '{chan_word(mem[slot_m][0]), 2'b01, 0, "R5 R6 R7"};
        end else begin
          it = '{{4'b0000, 4'(slot_m), 24'h0}, 2'b01, 0, "R8"};
        end
      end else if (slot_m == NCH) begin
        it = '{32'hD000_0000, 2'b01, 0, "R3"};
      end else begin
        it = '{32'h0, 2'b00, 0, "R4"};
      end
      slot_m = (slot_m == NSLOT-1) ? 0 : slot_m + 1;
      it.slot = slot_m;
    end else begin
      it = last;
      it.tag = "R2 hold";
    end
    check(fifo_pop == exp_pop, "R5/R8 pop", 64'(fifo_pop), 64'(exp_pop));
    @(posedge clk);
    #1;
    for (int c = 0; c < NCH; c++)
      if (exp_pop[c]) begin
        for (int k = 0; k < DEPTH-1; k++) mem[c][k] = mem[c][k+1];
        cnt[c]--;
      end
    refresh();
    armed_m = link_up && (armed_m || trig_seen);
    if (!act) slot_m = 18;
    last = it;
    sb.push_back(it);
    adv_en = 0;
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(tx_data == e.data, {e.tag, " data"}, 64'(tx_data), 64'(e.data));
      check(tx_ctl == e.ctl, {e.tag, " ctl"}, 64'(tx_ctl), 64'(e.ctl));
      check(int'(slot_num) == e.slot, "R2 slot", 64'(slot_num), 64'(e.slot));
      check(tx_ctl != 2'b10 && tx_ctl != 2'b11, "R12", 64'(tx_ctl), 64'(1));
    end
  end

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog R2 actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) cnt[c] = 0;
    refresh();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(slot_num == 5'd18, "R1 slot", 64'(slot_num), 64'd18);
    check(tx_ctl == 2'b00 && tx_data == 0, "R1 out", {30'h0, tx_ctl, tx_data}, 64'h0);
    check(fifo_pop == '0, "R1 pop", 64'(fifo_pop), 64'h0);
    rst_n = 1;

    link_up = 1; run_en = 1;
    load(0, 32'h3ABC_1234, 1'b0);
    for (int i = 0; i < 25; i++) tick(1, "R9");

    load(3, 32'hA0F0_0001, 1'b1);
    load(5, 32'h2000_0000, 1'b0);
    load(16, 32'h0000_0000, 1'b1);
    load(17, 32'h4123_4567, 1'b0);
    load(17, 32'h6FFF_FFFF, 1'b0);
    trig_seen = 1;
    tick(0, "R9");
    trig_seen = 0;
    for (int i = 0; i < 2*NSLOT; i++) begin
      tick(1, "R2");
      if (i % 3 == 0) tick(0, "R2");
    end

    load(9, 32'h7123_ABCD, 1'b1);
    load(1, 32'h0F0F_0F0F, 1'b0);
    for (int i = 0; i < 5; i++) tick(1, "R2");
    link_up = 0;
    for (int i = 0; i < 4; i++) tick(1, "R10");
    link_up = 1;
    for (int i = 0; i < 6; i++) tick(1, "R10");
    trig_seen = 1;
    tick(0, "R10");
    trig_seen = 0;
    for (int i = 0; i < NSLOT + 3; i++) tick(1, "R2");

    load(2, 32'hC555_AAAA, 1'b1);
    run_en = 0;
    for (int i = 0; i < 4; i++) tick(1, "R11");
    run_en = 1;
    for (int i = 0; i < NSLOT + 2; i++) tick(1, "R11");

    @(negedge clk);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule